// File: doc/BRIEF.md
# Serial Op-Code Command Port for a Label Filter Receiver

This block is the host-facing command port of a serial word receiver. A host acts as SPI master (mode 0). Each transaction opens when chip-select falls. The first eight SCK rising edges carry an op code, most significant bit first. The op code then fixes how many data bits follow and which way they flow: none, 8, 16, 32 or 256 bits, either written into the block or read out of it.

The block keeps a 16-bit control register and an 8-bit clock-divider register. For the rest of the receiver it issues single-cycle strobes and data: a master reset, whole-table clear and set of the label filter, single-label writes, bulk label writes and reads, and a pop of the receive FIFO.

All pins are oversampled in the core clock domain through synchronizers. Every command therefore reaches the core as a clean one-cycle pulse. Raising chip-select at any point ends the transaction.

Top module: `lbl_spi_regif`

## Requirements
- R1: After reset, `ctrl_reg` and `div_reg` are zero, every strobe is low and `spi_miso` is low. The op code is taken MSB first from the first eight SCK rising edges after chip-select falls.
- R2: Op code 0x10 followed by 16 bits (MSB first) loads `ctrl_reg`. Op code 0x0B returns `ctrl_reg` as 16 bits, MSB first.
- R3: Op code 0x07 followed by 8 bits loads `div_reg`. Op code 0x0A returns `div_reg` as 8 bits.
- R4: Op codes 0x01, 0x02 and 0x03 pulse `mr_stb`, `lbl_clr_all` and `lbl_set_all` respectively. Each pulse lasts one cycle and fires after the eighth op-code bit while chip-select is still low. At most one strobe is high in any cycle.
- R5: Op codes 0x04 and 0x05 take an 8-bit label number. After its last bit, one `lbl_wr` pulse is issued with `lbl_wr_addr` equal to that number and `lbl_wr_val` set to 0 for 0x04 or 1 for 0x05.
- R6: Op code 0x06 takes 256 bits. Data bit i (i = 0 for the first) issues one `lbl_wr` pulse with address 255 − i and the bit's value.
- R7: Op code 0x0D returns 256 bits. Bit i is `lbl_rd_bit` for `lbl_rd_addr` = 255 − i.
- R8: Op code 0x08 returns `fifo_word` as 32 bits, MSB first, and pulses `fifo_pop` once. If `fifo_empty` is high, it returns 32 zeros and does not pop.
- R9: Op code 0x0C returns the 8-bit `stat_in`, captured when the op code completes.
- R10: The first read bit drives `spi_miso` from the SCK falling edge after the eighth op-code bit. `spi_miso` is low while chip-select is high, during the op code, after the read field ends, and throughout write or empty op codes.
- R11: Op codes 0x00, 0x09, 0x0E and 0x0F, even when followed by further clocks, raise no strobe, leave both registers unchanged and keep `spi_miso` low.
- R12: A chip-select rise before a write field is complete discards that write. The next transaction decodes a fresh op code from its first bit.
- R13: SCK edges beyond the op code's data field are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, faster than 4× SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_csn | input | 1 | Chip-select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| mr_stb | output | 1 | Master-reset pulse |
| lbl_clr_all | output | 1 | Clear-all-labels pulse |
| lbl_set_all | output | 1 | Set-all-labels pulse |
| lbl_wr | output | 1 | Single label write pulse |
| lbl_wr_addr | output | 8 | Label number for `lbl_wr` |
| lbl_wr_val | output | 1 | Label enable value for `lbl_wr` |
| lbl_rd_addr | output | 8 | Label number being read in bulk |
| lbl_rd_bit | input | 1 | Enable bit of label `lbl_rd_addr` |
| fifo_word | input | 32 | Word at the head of the receive FIFO |
| fifo_empty | input | 1 | Receive FIFO holds no word |
| fifo_pop | output | 1 | Remove the head word |
| stat_in | input | 8 | Status byte to report |
| ctrl_reg | output | 16 | Control register |
| div_reg | output | 8 | Clock-divider register |

## Verification
The delicate overlap is the final SCK rise of a write field and the rise of chip-select that ends the transaction. Both arrive through the same synchronizer pipeline, one or two core cycles apart. The bench releases chip-select a single core clock after the last SCK rise of a control-register write, so the abort path and the commit pulse meet in adjacent cycles. The cycle-accurate model expects the write to commit exactly four clocks after that edge. It then confirms the value through a read-back, and checks by the same rule that aborts sent several SCK periods earlier discard their data.

// File: rtl/lbl_spi_pkg.sv
// Shared definitions for the serial command port.
// Assumes op-code values are fixed by the host protocol.
package lbl_spi_pkg;
    localparam int OP_BITS = 8;

    typedef enum logic [3:0] {
        K_NONE, K_MR, K_CLR_ALL, K_SET_ALL, K_LBL_RST, K_LBL_SET,
        K_BULK_WR, K_DIV_WR, K_FIFO_RD, K_STAT_RD, K_CTRL_RD,
        K_DIV_RD, K_BULK_RD, K_CTRL_WR
    } cmd_kind_t;

    localparam logic [7:0] OPC_MR      = 8'h01;
    localparam logic [7:0] OPC_CLR_ALL = 8'h02;
    localparam logic [7:0] OPC_SET_ALL = 8'h03;
    localparam logic [7:0] OPC_LBL_RST = 8'h04;
    localparam logic [7:0] OPC_LBL_SET = 8'h05;
    localparam logic [7:0] OPC_BULK_WR = 8'h06;
    localparam logic [7:0] OPC_DIV_WR  = 8'h07;
    localparam logic [7:0] OPC_FIFO_RD = 8'h08;
    localparam logic [7:0] OPC_DIV_RD  = 8'h0A;
    localparam logic [7:0] OPC_CTRL_RD = 8'h0B;
    localparam logic [7:0] OPC_STAT_RD = 8'h0C;
    localparam logic [7:0] OPC_BULK_RD = 8'h0D;
    localparam logic [7:0] OPC_CTRL_WR = 8'h10;
endpackage

// File: rtl/lbl_spi_sync.sv
// Pin synchronizer and edge finder for the SPI pins.
// Brings SCK, chip-select and MOSI into the core clock through STAGES
// flops each, so all three keep their relative timing. Produces SCK
// rise/fall pulses that are qualified by an active chip-select.
// Assumes the core clock is at least four times the SCK rate.
module lbl_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic csn,
    input  logic mosi,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    localparam int LANES = 3;
    localparam logic [LANES-1:0] IDLE = 3'b010; // {mosi, csn, sck}

    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_st
        logic [LANES-1:0] q;
        if (g == 0) begin : g_first
            // first stage captures the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) q <= IDLE;
                else        q <= {mosi, csn, sck};
            end
        end else begin : g_next
            // later stages resample the previous stage
            always_ff @(posedge clk) begin
                if (!rst_n) q <= IDLE;
                else        q <= g_st[g-1].q;
            end
        end
    end

    logic [LANES-1:0] pins_s;
    logic             sck_last;
    assign pins_s = g_st[STAGES-1].q;

    // remember the previous synchronized SCK level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_last <= 1'b0;
        else        sck_last <= pins_s[0];
    end

    assign cs_act   = ~pins_s[1];
    assign si_s     = pins_s[2];
    assign sck_rise = cs_act &  pins_s[0] & ~sck_last;
    assign sck_fall = cs_act & ~pins_s[0] &  sck_last;
endmodule

// File: rtl/lbl_spi_decode.sv
// Op-code decoder: maps an op code to its command kind, its data-field
// length in bits and whether the field flows out of the block.
// Unknown op codes decode to K_NONE with no data field.
module lbl_spi_decode
    import lbl_spi_pkg::*;
#(
    parameter int LBL_W  = 8,
    parameter int CTRL_W = 16,
    parameter int DIV_W  = 8,
    parameter int STAT_W = 8,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 9
) (
    input  logic [OP_BITS-1:0] op,
    output cmd_kind_t          kind,
    output logic [LEN_W-1:0]   len,
    output logic               is_rd
);
    localparam logic [LEN_W-1:0] L_LBL  = LEN_W'(LBL_W);
    localparam logic [LEN_W-1:0] L_CTRL = LEN_W'(CTRL_W);
    localparam logic [LEN_W-1:0] L_DIV  = LEN_W'(DIV_W);
    localparam logic [LEN_W-1:0] L_STAT = LEN_W'(STAT_W);
    localparam logic [LEN_W-1:0] L_WORD = LEN_W'(WORD_W);
    localparam logic [LEN_W-1:0] L_TBL  = LEN_W'(2 ** LBL_W);

    // table of kind, field length and direction per op code
    always_comb begin
        kind  = K_NONE;
        len   = '0;
        is_rd = 1'b0;
        case (op)
            OPC_MR:      kind = K_MR;
            OPC_CLR_ALL: kind = K_CLR_ALL;
            OPC_SET_ALL: kind = K_SET_ALL;
            OPC_LBL_RST: begin kind = K_LBL_RST; len = L_LBL; end
            OPC_LBL_SET: begin kind = K_LBL_SET; len = L_LBL; end
            OPC_BULK_WR: begin kind = K_BULK_WR; len = L_TBL; end
            OPC_DIV_WR:  begin kind = K_DIV_WR;  len = L_DIV; end
            OPC_CTRL_WR: begin kind = K_CTRL_WR; len = L_CTRL; end
            OPC_FIFO_RD: begin kind = K_FIFO_RD; len = L_WORD; is_rd = 1'b1; end
            OPC_DIV_RD:  begin kind = K_DIV_RD;  len = L_DIV;  is_rd = 1'b1; end
            OPC_CTRL_RD: begin kind = K_CTRL_RD; len = L_CTRL; is_rd = 1'b1; end
            OPC_STAT_RD: begin kind = K_STAT_RD; len = L_STAT; is_rd = 1'b1; end
            OPC_BULK_RD: begin kind = K_BULK_RD; len = L_TBL;  is_rd = 1'b1; end
            default:     kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/lbl_spi_engine.sv
// Bit-level transaction engine. Counts SCK rises from chip-select fall,
// assembles the op code, then shifts in up to fld_len data bits and
// counts read bits on SCK falls. All event outputs are one-cycle pulses,
// registered one cycle after the synchronized edge. Chip-select release
// clears the counters and any partial data.
module lbl_spi_engine
    import lbl_spi_pkg::*;
#(
    parameter int LEN_W = 9,
    parameter int SR_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_act,
    input  logic               sck_rise,
    input  logic               sck_fall,
    input  logic               si_s,
    input  logic [LEN_W-1:0]   fld_len,
    input  logic               fld_is_rd,
    output logic [OP_BITS-1:0] op_code,
    output logic               op_done,
    output logic               bit_stb,
    output logic [LEN_W-1:0]   bit_idx,
    output logic               bit_val,
    output logic               fld_done,
    output logic [SR_W-1:0]    fld_data,
    output logic               rd_shift
);
    localparam logic [LEN_W-1:0] OPB = LEN_W'(OP_BITS);

    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] rd_left;
    logic             in_op, in_fld, last_bit;

    assign in_op    = (cnt < OPB);
    assign in_fld   = !in_op && (cnt < OPB + fld_len);
    assign last_bit = (cnt == OPB + fld_len - LEN_W'(1));
    assign rd_shift = sck_fall && (rd_left != '0);

    // shift op code and write data, raise per-bit and completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            cnt      <= '0;
            op_done  <= 1'b0;
            bit_stb  <= 1'b0;
            fld_done <= 1'b0;
            bit_val  <= 1'b0;
            bit_idx  <= '0;
            fld_data <= '0;
            if (!rst_n) op_code <= '0;
        end else begin
            op_done  <= 1'b0;
            bit_stb  <= 1'b0;
            fld_done <= 1'b0;
            if (sck_rise && in_op) begin
                op_code <= {op_code[OP_BITS-2:0], si_s};
                op_done <= (cnt == OPB - LEN_W'(1));
                cnt     <= cnt + LEN_W'(1);
            end else if (sck_rise && in_fld) begin
                fld_data <= {fld_data[SR_W-2:0], si_s};
                bit_stb  <= 1'b1;
                bit_idx  <= cnt - OPB;
                bit_val  <= si_s;
                fld_done <= last_bit;
                cnt      <= cnt + LEN_W'(1);
            end
        end
    end

    // count the read bits still owed to the host
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act)       rd_left <= '0;
        else if (op_done && fld_is_rd) rd_left <= fld_len;
        else if (rd_shift)           rd_left <= rd_left - LEN_W'(1);
    end
endmodule

// File: rtl/lbl_spi_regif.sv
// Serial command port top. Synchronizes the SPI pins, decodes op codes,
// holds the control and divider registers, issues one-cycle strobes to
// the label table and receive FIFO, and serializes read data on MISO.
// Assumes lbl_rd_bit is a combinational lookup of lbl_rd_addr and that
// fifo_word shows the head word whenever fifo_empty is low.
module lbl_spi_regif
    import lbl_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LBL_W       = 8,
    parameter int CTRL_W      = 16,
    parameter int DIV_W       = 8,
    parameter int STAT_W      = 8,
    parameter int WORD_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              mr_stb,
    output logic              lbl_clr_all,
    output logic              lbl_set_all,
    output logic              lbl_wr,
    output logic [LBL_W-1:0]  lbl_wr_addr,
    output logic              lbl_wr_val,
    output logic [LBL_W-1:0]  lbl_rd_addr,
    input  logic              lbl_rd_bit,
    input  logic [WORD_W-1:0] fifo_word,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    input  logic [STAT_W-1:0] stat_in,
    output logic [CTRL_W-1:0] ctrl_reg,
    output logic [DIV_W-1:0]  div_reg
);
    localparam int LEN_W = $clog2(OP_BITS + 2 ** LBL_W + 1);
    localparam int SR_W  = CTRL_W;

    logic               cs_act, sck_rise, sck_fall, si_s;
    logic [OP_BITS-1:0] op_code;
    logic               op_done, bit_stb, bit_val, fld_done, rd_shift;
    logic [LEN_W-1:0]   bit_idx, fld_len;
    logic [SR_W-1:0]    fld_data;
    logic               fld_is_rd;
    cmd_kind_t          kind;
    logic [WORD_W-1:0]  out_sr;
    logic               so_q;
    logic               unused_idx;

    assign unused_idx = &{1'b0, bit_idx[LEN_W-1:LBL_W]};

    lbl_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csn(spi_csn),
        .mosi(spi_mosi), .cs_act(cs_act), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .si_s(si_s)
    );

    lbl_spi_decode #(
        .LBL_W(LBL_W), .CTRL_W(CTRL_W), .DIV_W(DIV_W),
        .STAT_W(STAT_W), .WORD_W(WORD_W), .LEN_W(LEN_W)
    ) u_dec (
        .op(op_code), .kind(kind), .len(fld_len), .is_rd(fld_is_rd)
    );

    lbl_spi_engine #(.LEN_W(LEN_W), .SR_W(SR_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .si_s(si_s), .fld_len(fld_len),
        .fld_is_rd(fld_is_rd), .op_code(op_code), .op_done(op_done),
        .bit_stb(bit_stb), .bit_idx(bit_idx), .bit_val(bit_val),
        .fld_done(fld_done), .fld_data(fld_data), .rd_shift(rd_shift)
    );

    // command strobes toward the label table and receive FIFO
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr_stb      <= 1'b0;
            lbl_clr_all <= 1'b0;
            lbl_set_all <= 1'b0;
            lbl_wr      <= 1'b0;
            lbl_wr_addr <= '0;
            lbl_wr_val  <= 1'b0;
            fifo_pop    <= 1'b0;
        end else begin
            mr_stb      <= op_done && (kind == K_MR);
            lbl_clr_all <= op_done && (kind == K_CLR_ALL);
            lbl_set_all <= op_done && (kind == K_SET_ALL);
            fifo_pop    <= op_done && (kind == K_FIFO_RD) && !fifo_empty;
            lbl_wr      <= 1'b0;
            if (bit_stb && kind == K_BULK_WR) begin
                lbl_wr      <= 1'b1;
                lbl_wr_addr <= ~bit_idx[LBL_W-1:0];
                lbl_wr_val  <= bit_val;
            end else if (fld_done && (kind == K_LBL_RST || kind == K_LBL_SET)) begin
                lbl_wr      <= 1'b1;
                lbl_wr_addr <= fld_data[LBL_W-1:0];
                lbl_wr_val  <= (kind == K_LBL_SET);
            end
        end
    end

    // control and divider registers, committed only on a complete field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_reg <= '0;
            div_reg  <= '0;
        end else if (fld_done) begin
            if (kind == K_CTRL_WR) ctrl_reg <= fld_data[CTRL_W-1:0];
            if (kind == K_DIV_WR)  div_reg  <= fld_data[DIV_W-1:0];
        end
    end

    // load the read word at op-code completion and shift it on SCK falls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sr <= '0;
        end else if (op_done) begin
            case (kind)
                K_FIFO_RD: out_sr <= fifo_empty ? '0 : fifo_word;
                K_STAT_RD: out_sr <= WORD_W'(stat_in)  << (WORD_W - STAT_W);
                K_CTRL_RD: out_sr <= WORD_W'(ctrl_reg) << (WORD_W - CTRL_W);
                K_DIV_RD:  out_sr <= WORD_W'(div_reg)  << (WORD_W - DIV_W);
                default:   out_sr <= '0;
            endcase
        end else if (rd_shift && kind != K_BULK_RD) begin
            out_sr <= out_sr << 1;
        end
    end

    // walk the label table downward during a bulk read
    always_ff @(posedge clk) begin
        if (!rst_n)                                lbl_rd_addr <= '1;
        else if (op_done && kind == K_BULK_RD)     lbl_rd_addr <= '1;
        else if (rd_shift && kind == K_BULK_RD)    lbl_rd_addr <= lbl_rd_addr - LBL_W'(1);
    end

    // MISO register: a read bit on each owed SCK fall, low otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) so_q <= 1'b0;
        else if (sck_fall) begin
            if (!rd_shift)              so_q <= 1'b0;
            else if (kind == K_BULK_RD) so_q <= lbl_rd_bit;
            else                        so_q <= out_sr[WORD_W-1];
        end
    end

    assign spi_miso = so_q;
endmodule

// File: rtl/lbl_spi_regif_chk.sv
// Property checker for the serial command port, bound into the top.
module lbl_spi_regif_chk #(
    parameter int CW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_act,
    input logic          fld_done,
    input logic          bit_stb,
    input logic          spi_miso,
    input logic          mr_stb,
    input logic          lbl_clr_all,
    input logic          lbl_set_all,
    input logic          lbl_wr,
    input logic          fifo_pop,
    input logic          fifo_empty,
    input logic [CW-1:0] ctrl_reg,
    input logic [DW-1:0] div_reg
);
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mr_stb, lbl_clr_all, lbl_set_all, lbl_wr, fifo_pop}));

    // R4
    mr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mr_stb |=> !mr_stb);

    // R4
    tbl_all_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lbl_clr_all || lbl_set_all) |=> !(lbl_clr_all || lbl_set_all));

    // R2
    ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_reg) |-> $past(fld_done));

    // R3
    div_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_reg) |-> $past(fld_done));

    // R5
    lbl_wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lbl_wr |-> $past(bit_stb));

    // R8
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> $past(!fifo_empty));

    // R10
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !spi_miso);
endmodule

bind lbl_spi_regif lbl_spi_regif_chk #(.CW(CTRL_W), .DW(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .fld_done(fld_done),
    .bit_stb(bit_stb), .spi_miso(spi_miso), .mr_stb(mr_stb),
    .lbl_clr_all(lbl_clr_all), .lbl_set_all(lbl_set_all),
    .lbl_wr(lbl_wr), .fifo_pop(fifo_pop), .fifo_empty(fifo_empty),
    .ctrl_reg(ctrl_reg), .div_reg(div_reg)
);

// File: tb/lbl_spi_regif_test.sv
// Bench: drives SPI transactions and keeps a behavioural model with a
// per-cycle event queue. Strobes and registers are compared every clock.
module lbl_spi_regif_test;
    localparam int CLK_P = 10;
    localparam int HALF  = 4;
    localparam int LAT   = 4;

    logic clk = 0, rst_n = 0;
    logic sck = 0, csn = 1, si = 0;
    logic miso, mr_stb, clr_all, set_all, lbl_wr, lbl_wr_val, fifo_pop;
    logic [7:0] lbl_wr_addr, lbl_rd_addr, stat_in = 8'h00, div_reg;
    logic [31:0] fifo_word = '0;
    logic fifo_empty = 1'b1;
    logic [15:0] ctrl_reg;
    logic [255:0] m_tbl = '0;
    logic lbl_rd_bit;
    assign lbl_rd_bit = m_tbl[lbl_rd_addr];

    lbl_spi_regif uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn),
        .spi_mosi(si), .spi_miso(miso), .mr_stb(mr_stb),
        .lbl_clr_all(clr_all), .lbl_set_all(set_all), .lbl_wr(lbl_wr),
        .lbl_wr_addr(lbl_wr_addr), .lbl_wr_val(lbl_wr_val),
        .lbl_rd_addr(lbl_rd_addr), .lbl_rd_bit(lbl_rd_bit),
        .fifo_word(fifo_word), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .stat_in(stat_in), .ctrl_reg(ctrl_reg), .div_reg(div_reg)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    string cur_req = "R1";

    typedef struct { int due; int kind; int addr; int val; } ev_t;
    ev_t evq[$];
    ev_t ev;
    logic [15:0] m_ctrl = '0;
    logic [7:0]  m_div  = '0;
    logic [4:0]  e_stb;
    logic [7:0]  e_addr;
    logic        e_val;

    task automatic chk(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // per-clock model: apply events due now, compare strobes and registers
    always @(negedge clk) if (rst_n) begin
        e_stb = '0; e_addr = '0; e_val = 0;
        while (evq.size() > 0 && evq[0].due <= cyc) begin
            ev = evq.pop_front();
            case (ev.kind)
                1: e_stb[4] = 1;
                2: begin e_stb[3] = 1; m_tbl = '0; end
                3: begin e_stb[2] = 1; m_tbl = '1; end
                4: begin e_stb[1] = 1; e_addr = ev.addr[7:0]; e_val = ev.val[0];
                         m_tbl[ev.addr] = ev.val[0]; end
                5: e_stb[0] = 1;
                6: m_ctrl = ev.val[15:0];
                7: m_div  = ev.val[7:0];
                default: ;
            endcase
        end
        chk({mr_stb, clr_all, set_all, lbl_wr, fifo_pop} == e_stb, cur_req,
            {mr_stb, clr_all, set_all, lbl_wr, fifo_pop}, e_stb);
        if (e_stb[1])
            chk({lbl_wr_addr, lbl_wr_val} == {e_addr, e_val}, cur_req,
                {lbl_wr_addr, lbl_wr_val}, {e_addr, e_val});
        chk(ctrl_reg == m_ctrl, cur_req, ctrl_reg, m_ctrl);
        chk(div_reg == m_div, cur_req, div_reg, m_div);
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int kind, input int addr, input int val);
        evq.push_back('{cyc + LAT, kind, addr, val});
    endtask

    // expected core events caused by the SCK rise of bit k
    task automatic sched(input logic [7:0] op, input int k, input int nd,
                         input logic [255:0] d);
        int j;
        j = k - 8;
        if (k == 7) begin
            if (op == 8'h01) push(1, 0, 0);
            if (op == 8'h02) push(2, 0, 0);
            if (op == 8'h03) push(3, 0, 0);
            if (op == 8'h08 && !fifo_empty) push(5, 0, 0);
        end
        if (k >= 8 && j < nd) begin
            if (op == 8'h06) push(4, 255 - j, int'(d[nd-1-j]));
            if (j == nd - 1) begin
                if (op == 8'h04) push(4, int'(d[7:0]), 0);
                if (op == 8'h05) push(4, int'(d[7:0]), 1);
                if (op == 8'h07) push(7, 0, int'(d[7:0]));
                if (op == 8'h10) push(6, 0, int'(d[15:0]));
            end
        end
    endtask

    task automatic xfer(input logic [7:0] op, input int nd, input logic [255:0] d,
                        input int nclk, input int gap, input bit isrd,
                        output logic [255:0] rd);
        rd = '0;
        csn = 0; sck = 0;
        wait_n(HALF);
        for (int k = 0; k < nclk; k++) begin
            int j;
            j = k - 8;
            if (k < 8)       si = op[7-k];
            else if (j < nd) si = d[nd-1-j];
            else             si = 1'b1;
            wait_n(HALF);
            if (isrd && k >= 8 && j < nd) rd[nd-1-j] = miso;
            else chk(miso == 1'b0, "R10", miso, 0);
            sck = 1;
            sched(op, k, nd, d);
            if (k == nclk - 1) begin
                wait_n(gap); csn = 1; wait_n(HALF); sck = 0;
            end else begin
                wait_n(HALF); sck = 0;
            end
        end
        if (nclk == 0) begin wait_n(HALF); csn = 1; end
        wait_n(8);
        chk(miso == 1'b0, "R10", miso, 0);
    endtask

    task automatic wr(input logic [7:0] op, input int nd, input logic [255:0] d);
        logic [255:0] rd;
        xfer(op, nd, d, 8 + nd, HALF, 0, rd);
    endtask

    task automatic rd_chk(input logic [7:0] op, input int nd,
                          input logic [255:0] exp, input string req);
        logic [255:0] rd;
        xfer(op, nd, '0, 8 + nd, HALF, 1, rd);
        chk(rd == exp, req, rd, exp);
    endtask

    logic [255:0] pat, junk;

    initial begin
        wait_n(5);
        // R1 reset state
        chk(ctrl_reg == 0 && div_reg == 0, "R1", {ctrl_reg, div_reg}, 0);
        chk({mr_stb, clr_all, set_all, lbl_wr, fifo_pop, miso} == 0, "R1",
            {mr_stb, clr_all, set_all, lbl_wr, fifo_pop, miso}, 0);
        rst_n = 1;
        wait_n(4);

        cur_req = "R2";
        wr(8'h10, 16, 256'hA5C3);
        rd_chk(8'h0B, 16, 256'hA5C3, "R2");
        wr(8'h10, 16, 256'h3C0F);
        rd_chk(8'h0B, 16, 256'h3C0F, "R2");

        cur_req = "R3";
        wr(8'h07, 8, 256'h0A);
        rd_chk(8'h0A, 8, 256'h0A, "R3");

        cur_req = "R4";
        wr(8'h01, 0, '0);
        wr(8'h03, 0, '0);
        rd_chk(8'h0D, 256, {256{1'b1}}, "R7");
        wr(8'h02, 0, '0);
        rd_chk(8'h0D, 256, '0, "R7");

        cur_req = "R5";
        wr(8'h05, 8, 256'h2C);
        wr(8'h05, 8, 256'hFF);
        wr(8'h05, 8, 256'h00);
        wr(8'h04, 8, 256'hFF);
        pat = '0; pat[8'h2C] = 1; pat[0] = 1;
        rd_chk(8'h0D, 256, pat, "R5");

        cur_req = "R6";
        pat = {8{32'hB3D1_0F96}} ^ {4{64'h0123_4567_89AB_CDEF}};
        wr(8'h06, 256, pat);
        rd_chk(8'h0D, 256, pat, "R6");

        cur_req = "R8";
        fifo_word = 32'h9C3E_71A5; fifo_empty = 0;
        rd_chk(8'h08, 32, 256'h9C3E_71A5, "R8");
        fifo_empty = 1;
        rd_chk(8'h08, 32, '0, "R8");

        cur_req = "R9";
        stat_in = 8'h5A;
        rd_chk(8'h0C, 8, 256'h5A, "R9");
        stat_in = 8'hC1;
        rd_chk(8'h0C, 8, 256'hC1, "R9");

        cur_req = "R11";
        xfer(8'h00, 0, '0, 16, HALF, 0, junk);
        xfer(8'h09, 0, '0, 16, HALF, 0, junk);
        xfer(8'h0E, 0, '0, 24, HALF, 0, junk);
        xfer(8'h0F, 0, '0, 16, HALF, 0, junk);
        rd_chk(8'h0B, 16, 256'h3C0F, "R11");

        cur_req = "R12";
        xfer(8'h10, 16, 256'hFFFF, 18, HALF, 0, junk);
        xfer(8'h05, 8, 256'h77, 13, HALF, 0, junk);
        xfer(8'h07, 8, 256'h55, 5, HALF, 0, junk);
        rd_chk(8'h0B, 16, 256'h3C0F, "R12");
        rd_chk(8'h0A, 8, 256'h0A, "R12");

        cur_req = "R13";
        xfer(8'h07, 8, 256'h81, 22, HALF, 0, junk);
        rd_chk(8'h0A, 8, 256'h81, "R13");

        // commit vs chip-select release one clock after the last rise
        cur_req = "R2";
        xfer(8'h10, 16, 256'h6E29, 24, 1, 0, junk);
        rd_chk(8'h0B, 16, 256'h6E29, "R2");

        wait_n(10);
        chk(evq.size() == 0, "R4", evq.size(), 0);
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            chk(1'b0, "watchdog", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule